// File: doc/BRIEF.md
# Mixed-Length Instruction Aligner

This block sits between an instruction fetch buffer and the instruction decoder. Fetch supplies 64-bit words, and the aligner cuts the byte stream into instructions of 2, 3 or 8 bytes. These lengths can appear in any order with no mode setting. The length of each instruction comes from the low nibble of its first byte. A long instruction that starts near the end of one fetch word is completed from the next word.

The aligner keeps up to 16 bytes in a staging buffer, together with a byte count. It issues at most one instruction per cycle on a valid/ready port. Each issued instruction is placed at bit 0 of a 64-bit output, its unused upper bytes are zero, and it carries a 2-bit length code. On a taken branch, a one-cycle flush input discards everything that is buffered.

Top module: `ilen_aligner`

## Requirements
- R1: A first byte whose low nibble is 15 (4'hF) marks an 8-byte instruction, reported with length code 2.
- R2: A low nibble in the range 8 to 14 marks a 2-byte instruction, reported with length code 0.
- R3: A low nibble in the range 0 to 7 marks a 3-byte instruction, reported with length code 1.
- R4: Fetch byte k is `in_word[8k+7:8k]`, and lower bytes come first in the stream. Instructions are packed back to back in any mix of lengths and may straddle fetch words.
- R5: `out_valid` is high only when the buffer holds at least as many bytes as the head instruction needs. Otherwise the aligner waits for more fetch data.
- R6: `out_insn` carries the instruction's bytes, first byte at bits [7:0]. Bytes beyond the instruction's length are zero.
- R7: `in_ready` is high exactly when no flush is present and at most 8 bytes are buffered. A word is taken when `in_valid` and `in_ready` are both high.
- R8: While `out_valid` is high and `out_ready` is low, `out_insn` and `out_len` stay unchanged.
- R9: In a flush cycle, `in_ready` and `out_valid` are low and the buffer is emptied. The next accepted word starts alignment at its byte 0.
- R10: After reset the buffer is empty: `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| flush | input | 1 | Discard all buffered bytes (taken branch) |
| in_valid | input | 1 | Fetch word present |
| in_ready | output | 1 | Aligner can take a fetch word |
| in_word | input | 64 | Fetch word, byte 0 in bits [7:0] |
| out_valid | output | 1 | Aligned instruction present |
| out_ready | input | 1 | Decoder takes the instruction |
| out_insn | output | 64 | Aligned instruction, zero-padded |
| out_len | output | 2 | Length code: 0 = 16, 1 = 24, 2 = 64 bits |

## Verification
The hardest state to reach is a partly buffered 8-byte instruction that must wait for the next word while the buffer is nearly full. The stream of mixed lengths places long instructions across word boundaries. A recurring pattern of fetch gaps and decoder stalls drives the byte count through every value up to 16, including the point where fetch is refused. The stream ends with seven bytes of an unfinished long instruction, which the aligner must hold without issuing. A flush then has to discard those bytes before the next word is aligned from byte 0.

// File: rtl/ilen_pkg.sv
package ilen_pkg;

  typedef enum logic [1:0] {
    LEN_16 = 2'd0,
    LEN_24 = 2'd1,
    LEN_64 = 2'd2
  } ilen_code_e;

  localparam logic [3:0] LONG_TAG = 4'hF;
  localparam logic [3:0] SHORT_LO = 4'h8;

  function automatic logic [3:0] code_bytes(ilen_code_e c);
    case (c)
      LEN_16:  code_bytes = 4'd2;
      LEN_24:  code_bytes = 4'd3;
      default: code_bytes = 4'd8;
    endcase
  endfunction

endpackage

// File: rtl/ilen_classify.sv
module ilen_classify
  import ilen_pkg::*;
(
  input  logic [3:0] tag,
  output ilen_code_e code,
  output logic [3:0] nbytes
);

  always_comb begin
    if (tag == LONG_TAG) begin
      code   = LEN_64;
      nbytes = 4'd8;
    end else if (tag >= SHORT_LO) begin
      code   = LEN_16;
      nbytes = 4'd2;
    end else begin
      code   = LEN_24;
      nbytes = 4'd3;
    end
  end

endmodule

// File: rtl/ilen_stage.sv
module ilen_stage #(
  parameter int WORD_BYTES = 8,
  parameter int BUF_BYTES  = 16,
  parameter int CNT_W      = $clog2(BUF_BYTES + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     flush,
  input  logic                     accept,
  input  logic [WORD_BYTES*8-1:0]  word,
  input  logic [CNT_W-1:0]         consume_bytes,
  output logic [BUF_BYTES*8-1:0]   buf_q,
  output logic [CNT_W-1:0]         cnt_q
);

  localparam int WORD_W = WORD_BYTES * 8;
  localparam int BUF_W  = BUF_BYTES * 8;

  logic [BUF_W-1:0] buf_d, shifted, placed;
  logic [CNT_W-1:0] cnt_d, rem;
  logic             upd;

  // bytes at and above cnt_q are kept zero, so appending is a plain OR
  always_comb begin
    rem     = cnt_q - consume_bytes;
    shifted = buf_q >> {consume_bytes, 3'b000};
    placed  = {{(BUF_W - WORD_W){1'b0}}, word} << {rem, 3'b000};
    upd     = flush | accept | (consume_bytes != '0);
    if (flush) begin
      buf_d = '0;
      cnt_d = '0;
    end else if (accept) begin
      buf_d = shifted | placed;
      cnt_d = rem + CNT_W'(WORD_BYTES);
    end else begin
      buf_d = shifted;
      cnt_d = rem;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q <= '0;
      cnt_q <= '0;
    end else if (upd) begin
      buf_q <= buf_d;
      cnt_q <= cnt_d;
    end
  end

  p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(BUF_BYTES));

  p_flush_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> cnt_q == '0);

  p_consume_avail_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (consume_bytes != '0) |-> consume_bytes <= cnt_q);

endmodule

// File: rtl/ilen_mask.sv
module ilen_mask #(
  parameter int OUT_BYTES = 8,
  parameter int NB_W      = $clog2(OUT_BYTES + 1)
) (
  input  logic [OUT_BYTES*8-1:0] raw,
  input  logic [NB_W-1:0]        nbytes,
  output logic [OUT_BYTES*8-1:0] masked
);

  for (genvar b = 0; b < OUT_BYTES; b++) begin : g_byte
    assign masked[8*b +: 8] = (NB_W'(b) < nbytes) ? raw[8*b +: 8] : 8'h00;
  end

endmodule

// File: rtl/ilen_aligner.sv
module ilen_aligner
  import ilen_pkg::*;
#(
  parameter int WORD_BYTES = 8,
  parameter int BUF_BYTES  = 16,
  parameter int INSN_BYTES = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    flush,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [WORD_BYTES*8-1:0] in_word,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic [INSN_BYTES*8-1:0] out_insn,
  output logic [1:0]              out_len
);

  localparam int CNT_W  = $clog2(BUF_BYTES + 1);
  localparam int INSN_W = INSN_BYTES * 8;
  localparam int BUF_W  = BUF_BYTES * 8;
  localparam int NB_W   = 4;

  // asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic [BUF_W-1:0]  buf_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [CNT_W-1:0]  consume;
  ilen_code_e        code;
  logic [NB_W-1:0]   nbytes;
  logic              have, fire, accept;

  ilen_classify u_cls (
    .tag    (buf_q[3:0]),
    .code   (code),
    .nbytes (nbytes)
  );

  always_comb begin
    have      = cnt_q >= CNT_W'(nbytes);
    out_valid = have & ~flush;
    fire      = out_valid & out_ready;
    in_ready  = ~flush & (cnt_q <= CNT_W'(BUF_BYTES - WORD_BYTES));
    accept    = in_valid & in_ready;
    consume   = fire ? CNT_W'(nbytes) : '0;
    out_len   = code;
  end

  ilen_stage #(
    .WORD_BYTES (WORD_BYTES),
    .BUF_BYTES  (BUF_BYTES),
    .CNT_W      (CNT_W)
  ) u_stage (
    .clk           (clk),
    .rst_n         (rst_int_n),
    .flush         (flush),
    .accept        (accept),
    .word          (in_word),
    .consume_bytes (consume),
    .buf_q         (buf_q),
    .cnt_q         (cnt_q)
  );

  ilen_mask #(
    .OUT_BYTES (INSN_BYTES),
    .NB_W      (NB_W)
  ) u_mask (
    .raw    (buf_q[INSN_W-1:0]),
    .nbytes (nbytes),
    .masked (out_insn)
  );

  p_enough_bytes_r5: assert property (@(posedge clk) disable iff (!rst_int_n)
    out_valid |-> cnt_q >= CNT_W'(code_bytes(ilen_code_e'(out_len))));

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_int_n)
    (out_valid && !out_ready) |=>
      (flush || (out_valid && $stable(out_insn) && $stable(out_len))));

  p_long_tag_r1: assert property (@(posedge clk) disable iff (!rst_int_n)
    (out_valid && out_insn[3:0] == 4'hF) |-> out_len == 2'd2);

  p_flush_quiet_r9: assert property (@(posedge clk) disable iff (!rst_int_n)
    flush |-> (!out_valid && !in_ready));

endmodule

// File: tb/ilen_aligner_test.sv
`timescale 1ns/1ps
module ilen_aligner_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flush = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [63:0] in_word = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [63:0] out_insn;
  logic [1:0]  out_len;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  ilen_aligner uut (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .in_valid(in_valid), .in_ready(in_ready), .in_word(in_word),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_insn(out_insn), .out_len(out_len)
  );

  // {length code, zero-padded instruction}
  localparam int NV = 14;
  localparam logic [65:0] VEC [NV] = '{
    {2'd1, 64'h0000_0000_00A1_B2C3},
    {2'd0, 64'h0000_0000_0000_5D48},
    {2'd2, 64'h0123_4567_89AB_CDEF},
    {2'd0, 64'h0000_0000_0000_E7CE},
    {2'd1, 64'h0000_0000_0011_2230},
    {2'd2, 64'hFEDC_BA98_7654_321F},
    {2'd2, 64'h8000_0000_0000_000F},
    {2'd1, 64'h0000_0000_00FF_FF07},
    {2'd0, 64'h0000_0000_0000_12A9},
    {2'd0, 64'h0000_0000_0000_340B},
    {2'd1, 64'h0000_0000_0055_6614},
    {2'd2, 64'hA5A5_5A5A_C3C3_3C3F},
    {2'd1, 64'h0000_0000_0000_0002},
    {2'd0, 64'h0000_0000_0000_FFFC}
  };

  logic [7:0]  strm [64];
  logic [63:0] words [8];

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic int nb(input logic [1:0] c);
    return (c == 2'd0) ? 2 : (c == 2'd1) ? 3 : 8;
  endfunction

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin : main
    int pos, widx, oidx, cyc;
    logic [63:0] held;

    // build the byte stream, pad with an unfinished long instruction (0xFF)
    pos = 0;
    for (int i = 0; i < NV; i++) begin
      for (int k = 0; k < nb(VEC[i][65:64]); k++) strm[pos + k] = VEC[i][8*k +: 8];
      pos += nb(VEC[i][65:64]);
    end
    for (int p = pos; p < 64; p++) strm[p] = 8'hFF;
    for (int w = 0; w < 8; w++)
      for (int k = 0; k < 8; k++) words[w][8*k +: 8] = strm[8*w + k];

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    chk(out_valid == 1'b0, "R10 out_valid after reset", 64'(out_valid), 64'd0);
    chk(in_ready == 1'b1, "R10 in_ready after reset", 64'(in_ready), 64'd1);

    // table walk: mixed lengths with fetch gaps and decoder stalls (R1 R2 R3 R4 R6 R7)
    widx = 0; oidx = 0; cyc = 0;
    while ((oidx < NV || widx < 8) && cyc < 2000) begin
      @(negedge clk);
      in_valid  = (widx < 8) && (cyc % 7 != 2);
      in_word   = (widx < 8) ? words[widx] : 64'h0;
      out_ready = (cyc % 5 != 3);
      #1;
      if (out_valid && out_ready && oidx < NV) begin
        chk(out_insn == VEC[oidx][63:0], "R4/R6 instruction bytes", out_insn, VEC[oidx][63:0]);
        chk(out_len == VEC[oidx][65:64], "R1/R2/R3 length code", 64'(out_len), 64'(VEC[oidx][65:64]));
        oidx++;
      end
      if (in_valid && in_ready) widx++;
      cyc++;
    end
    chk(oidx == NV, "R4 all instructions issued", 64'(oidx), 64'(NV));
    @(negedge clk);
    in_valid = 1'b0; out_ready = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    chk(out_valid == 1'b0, "R5 partial long instruction held", 64'(out_valid), 64'd0);

    // flush with seven stale bytes buffered (R9)
    @(negedge clk);
    flush = 1'b1; in_valid = 1'b1; in_word = 64'h2211_0FA1_B2C3_5D48;
    #1;
    chk(in_ready == 1'b0, "R9 in_ready low during flush", 64'(in_ready), 64'd0);
    chk(out_valid == 1'b0, "R9 out_valid low during flush", 64'(out_valid), 64'd0);
    @(negedge clk);
    flush = 1'b0;
    #1;
    chk(out_valid == 1'b0, "R9 buffer empty after flush", 64'(out_valid), 64'd0);
    chk(in_ready == 1'b1, "R7 ready with empty buffer", 64'(in_ready), 64'd1);
    // word accepted at next edge, alignment from byte 0
    @(negedge clk);
    in_valid = 1'b0;
    #1;
    chk(out_valid && out_insn == 64'h5D48, "R9 restart at byte 0", out_insn, 64'h5D48);
    chk(out_len == 2'd0, "R2 short code", 64'(out_len), 64'd0);
    @(negedge clk);
    #1;
    chk(out_valid && out_insn == 64'hA1B2C3, "R3 24-bit after short", out_insn, 64'hA1B2C3);
    chk(out_len == 2'd1, "R3 code", 64'(out_len), 64'd1);
    @(negedge clk);
    #1;
    chk(out_valid == 1'b0, "R5 three of eight bytes", 64'(out_valid), 64'd0);

    // straddling long instruction under decoder stall (R4 R7 R8)
    out_ready = 1'b0; in_valid = 1'b1; in_word = 64'h9988_7766_5544_3322;
    @(negedge clk);
    in_valid = 1'b0;
    #1;
    chk(out_valid && out_insn == 64'h6655_4433_2222_110F, "R4 straddling long instruction",
        out_insn, 64'h6655_4433_2222_110F);
    chk(out_len == 2'd2, "R1 long code", 64'(out_len), 64'd2);
    chk(in_ready == 1'b0, "R7 refuse with 11 bytes", 64'(in_ready), 64'd0);
    held = out_insn;
    repeat (2) @(negedge clk);
    #1;
    chk(out_valid && out_insn == held && out_len == 2'd2, "R8 held under stall", out_insn, held);
    out_ready = 1'b1;
    @(negedge clk);
    #1;
    chk(out_valid && out_insn == 64'h99_8877, "R3 tail after long", out_insn, 64'h99_8877);
    chk(in_ready == 1'b1, "R7 ready with 3 bytes", 64'(in_ready), 64'd1);
    @(negedge clk);
    #1;
    chk(out_valid == 1'b0, "R5 empty after drain", 64'(out_valid), 64'd0);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule